// File: doc/BRIEF.md
# Parallel Port Strobe Timing Generator

This block is the output-side transfer engine of a bidirectional parallel port. Software programs two 7-bit tick counts: how long data must be stable before the strobe, and how long the strobe stays asserted. It then writes a byte to the data register. The engine drives the byte onto the port lines and waits the setup count. It then raises the data strobe for the width count, drops it and returns to idle. Both counts are in clock cycles.

A small register port gives access to four registers: timing, operation control, transfer control and data. Each register is 16 bits wide and selected by a 2-bit address:

| Address | Register |
|---|---|
| 0 | timing |
| 1 | operation control |
| 2 | transfer control |
| 3 | data |

Read data is registered and is valid one cycle after the address is presented. A sticky soft-reset bit parks the engine. An idle flag shows when a new byte may be written. A test bit makes the timing register return the live phase counter. The ACK and BUSY pins pass through a two-stage synchronizer and can be read back.

Top module: `pp_strobe_gen`

## Requirements
- R1: After reset, the strobe is 0 and the data lines are 0x00. The driver enable is 1, so the direction is output. Reading operation control returns 0x0008, and the timing and transfer control registers read 0x0000.
- R2: A write to the data register (address 3) starts a transfer when the engine is idle, the direction is output and soft reset is 0. The byte appears on `pp_data_out` after the write edge and stays unchanged until the engine is idle again.
- R3: The setup phase lasts exactly S cycles. S is timing bits 6:0, and a value of 0 counts as 1. The strobe rises S clock edges after the write edge.
- R4: The strobe stays high for exactly W cycles. W is timing bits 14:8, and a value of 0 counts as 1. The strobe then falls and the engine returns to idle.
- R5: A data write that arrives while a transfer is in progress has no effect. The data lines and the transferred byte are not changed.
- R6: Transfer control bit 3 sets the direction, where 1 means input. While it is 1, `pp_drv_en` is 0 and data writes start no transfer.
- R7: Operation control bit 7 is a soft reset. When it is set, a running transfer stops within two edges of the write, with the strobe low and the engine idle. The engine stays idle while the bit is 1, and the bit reads back as 1 until software clears it.
- R8: Operation control bit 3 reads 1 while the engine is idle and 0 during the setup and strobe phases.
- R9: Transfer control reads back four bits: bit 3 is the direction, bit 2 is BUSY, bit 1 is ACK and bit 0 is the current strobe. BUSY and ACK are taken after two synchronizer stages.
- R10: With timing bit 15 set, a timing read returns bit 15 as 1 and the live phase counter. The counter appears in bits 6:0 during setup and in bits 14:8 during strobe, with all other bits 0.
- R11: With timing bit 15 clear, a timing read returns the programmed setup and width fields, with bits 15 and 7 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all ticks are counted on this clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 timing, 1 operation control, 2 transfer control, 3 data |
| reg_wr_en | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data for the address of the previous cycle |
| pp_data_out | output | 8 | Port data lines |
| pp_strobe | output | 1 | Data strobe, active high |
| pp_drv_en | output | 1 | Data line driver enable (1 = output direction) |
| pp_ack_in | input | 1 | ACK pin from the peripheral |
| pp_busy_in | input | 1 | BUSY pin from the peripheral |

## Verification
Each result has a fixed due time, counted from the clock edge that captures the data write:

- The byte appears on the data lines right after that edge.
- The strobe rises S edges after it and falls W edges after that.

The scoreboard monitor stamps each write and each strobe edge with a cycle counter, sampled on the falling clock edge, and compares the differences with S and W.

Register reads are sampled one cycle after the address is driven. Pin readback is checked only after the two synchronizer stages plus the read register have settled. The soft-reset check samples the strobe both one and two falling edges after the write. This confirms that the abort lands on the second edge.

// File: rtl/pp_strobe_pkg.sv
package pp_strobe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2
  } xfer_state_t;

  localparam logic [1:0] ADDR_TIMING = 2'd0;
  localparam logic [1:0] ADDR_OPCTL  = 2'd1;
  localparam logic [1:0] ADDR_XCTL   = 2'd2;
  localparam logic [1:0] ADDR_DATA   = 2'd3;

  localparam int TIM_WIDTH_LSB = 8;
  localparam int TIM_TEST_BIT  = 15;
  localparam int OP_SRST_BIT   = 7;
  localparam int OP_IDLE_BIT   = 3;
  localparam int XC_DIR_BIT    = 3;
  localparam int XC_BUSY_BIT   = 2;
  localparam int XC_ACK_BIT    = 1;
  localparam int XC_STB_BIT    = 0;
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/pp_xfer_fsm.sv
module pp_xfer_fsm
  import pp_strobe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              srst,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic [CNT_W-1:0]  setup_cnt,
  input  logic [CNT_W-1:0]  width_cnt,
  output logic [DATA_W-1:0] data_q,
  output logic              strobe_q,
  output xfer_state_t       state_q,
  output logic [CNT_W-1:0]  cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else if (srst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SETUP;
            cnt_q   <= at_least_one(setup_cnt);
            data_q  <= start_data;
          end
        end
        ST_SETUP: begin
          if (cnt_q <= ONE) begin
            state_q  <= ST_STROBE;
            cnt_q    <= at_least_one(width_cnt);
            strobe_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_STROBE: begin
          if (cnt_q <= ONE) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            strobe_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: begin
          state_q  <= ST_IDLE;
          strobe_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/pp_regs.sv
module pp_regs
  import pp_strobe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 7,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  input  xfer_state_t       st,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [DATA_W-1:0] data_q,
  input  logic              strobe_q,
  input  logic              ack_s,
  input  logic              busy_s,
  output logic [CNT_W-1:0]  setup_cnt,
  output logic [CNT_W-1:0]  width_cnt,
  output logic              srst,
  output logic              dir_in,
  output logic              start,
  output logic [DATA_W-1:0] start_data
);
  logic             test_mode;
  logic [REG_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      setup_cnt <= '0;
      width_cnt <= '0;
      test_mode <= 1'b0;
      srst      <= 1'b0;
      dir_in    <= 1'b0;
    end else if (wr_en) begin
      unique case (addr)
        ADDR_TIMING: begin
          setup_cnt <= wdata[CNT_W-1:0];
          width_cnt <= wdata[TIM_WIDTH_LSB +: CNT_W];
          test_mode <= wdata[TIM_TEST_BIT];
        end
        ADDR_OPCTL: srst   <= wdata[OP_SRST_BIT];
        ADDR_XCTL:  dir_in <= wdata[XC_DIR_BIT];
        default: ;
      endcase
    end
  end

  assign start      = wr_en && (addr == ADDR_DATA) && (st == ST_IDLE) && !dir_in && !srst;
  assign start_data = wdata[DATA_W-1:0];

  always_comb begin
    rd_next = '0;
    unique case (addr)
      ADDR_TIMING: begin
        rd_next[TIM_TEST_BIT] = test_mode;
        if (test_mode) begin
          rd_next[CNT_W-1:0]               = (st == ST_SETUP)  ? cnt : '0;
          rd_next[TIM_WIDTH_LSB +: CNT_W]  = (st == ST_STROBE) ? cnt : '0;
        end else begin
          rd_next[CNT_W-1:0]               = setup_cnt;
          rd_next[TIM_WIDTH_LSB +: CNT_W]  = width_cnt;
        end
      end
      ADDR_OPCTL: begin
        rd_next[OP_SRST_BIT] = srst;
        rd_next[OP_IDLE_BIT] = (st == ST_IDLE);
      end
      ADDR_XCTL: begin
        rd_next[XC_DIR_BIT]  = dir_in;
        rd_next[XC_BUSY_BIT] = busy_s;
        rd_next[XC_ACK_BIT]  = ack_s;
        rd_next[XC_STB_BIT]  = strobe_q;
      end
      default: rd_next[DATA_W-1:0] = data_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/pp_strobe_gen.sv
module pp_strobe_gen
  import pp_strobe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 7,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [DATA_W-1:0] pp_data_out,
  output logic              pp_strobe,
  output logic              pp_drv_en,
  input  logic              pp_ack_in,
  input  logic              pp_busy_in
);
  localparam int PIN_W = 2;

  xfer_state_t       xfer_st;
  logic [CNT_W-1:0]  phase_cnt;
  logic [CNT_W-1:0]  setup_cnt;
  logic [CNT_W-1:0]  width_cnt;
  logic              srst_q;
  logic              dir_in;
  logic              start;
  logic [DATA_W-1:0] start_data;
  logic [PIN_W-1:0]  pins_s;

  pp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({pp_busy_in, pp_ack_in}),
    .dout (pins_s)
  );

  pp_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (reg_addr),
    .wr_en      (reg_wr_en),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .st         (xfer_st),
    .cnt        (phase_cnt),
    .data_q     (pp_data_out),
    .strobe_q   (pp_strobe),
    .ack_s      (pins_s[0]),
    .busy_s     (pins_s[1]),
    .setup_cnt  (setup_cnt),
    .width_cnt  (width_cnt),
    .srst       (srst_q),
    .dir_in     (dir_in),
    .start      (start),
    .start_data (start_data)
  );

  pp_xfer_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .srst       (srst_q),
    .start      (start),
    .start_data (start_data),
    .setup_cnt  (setup_cnt),
    .width_cnt  (width_cnt),
    .data_q     (pp_data_out),
    .strobe_q   (pp_strobe),
    .state_q    (xfer_st),
    .cnt_q      (phase_cnt)
  );

  assign pp_drv_en = ~dir_in;
endmodule

// File: rtl/pp_strobe_chk.sv
module pp_strobe_chk
  import pp_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              pp_strobe,
  input logic [DATA_W-1:0] pp_data_out,
  input xfer_state_t       xfer_st,
  input logic              srst_q
);
  // R2: data held while a transfer continues
  a_r2_data_held: assert property (@(posedge clk) disable iff (rst)
    (xfer_st != ST_IDLE && $past(xfer_st) != ST_IDLE) |-> $stable(pp_data_out));

  // R3: strobe rises only out of the setup phase
  a_r3_rise_after_setup: assert property (@(posedge clk) disable iff (rst)
    $rose(pp_strobe) |-> ($past(xfer_st) == ST_SETUP));

  // R4: strobe falls only when the engine returns to idle
  a_r4_fall_to_idle: assert property (@(posedge clk) disable iff (rst)
    $fell(pp_strobe) |-> (xfer_st == ST_IDLE));

  // R7: soft reset parks the engine on the next edge
  a_r7_srst_parks: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (xfer_st == ST_IDLE && !pp_strobe));

  // R8: no strobe while idle
  a_r8_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (xfer_st == ST_IDLE) |-> !pp_strobe);
endmodule

bind pp_strobe_gen pp_strobe_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pp_strobe   (pp_strobe),
  .pp_data_out (pp_data_out),
  .xfer_st     (xfer_st),
  .srst_q      (srst_q)
);

// File: tb/tb_pp_strobe_gen.sv
module tb_pp_strobe_gen;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [7:0] data;
    int         setup;
    int         width;
    int         start;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic        reg_wr_en = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  pp_data_out;
  logic        pp_strobe;
  logic        pp_drv_en;
  logic        pp_ack_in = 1'b0;
  logic        pp_busy_in = 1'b0;

  int   cyc = 0;
  int   n_checks = 0;
  int   n_errors = 0;
  bit   abort_ok = 1'b0;
  bit   stb_prev = 1'b0;
  bit   finished = 1'b0;
  exp_t sb_q[$];

  pp_strobe_gen dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pp_data_out(pp_data_out),
    .pp_strobe(pp_strobe), .pp_drv_en(pp_drv_en), .pp_ack_in(pp_ack_in),
    .pp_busy_in(pp_busy_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wr_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // driver: start a transfer and push what the monitor must see
  task automatic send(input logic [7:0] d, input int s, input int w);
    exp_t e;
    reg_wr(2'd3, {8'h00, d});
    e.data  = d;
    e.setup = eff(s);
    e.width = eff(w);
    e.start = cyc;
    sb_q.push_back(e);
  endtask

  task automatic wait_idle();
    logic [15:0] r;
    r = '0;
    while (r[3] == 1'b0) reg_rd(2'd1, r);
  endtask

  // monitor: measure setup and width at strobe edges
  int rise_cyc = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (pp_strobe && !stb_prev) begin
        rise_cyc = cyc;
        if (sb_q.size() > 0) begin
          check(rise_cyc - sb_q[0].start == sb_q[0].setup, "R3 setup cycles",
                rise_cyc - sb_q[0].start, sb_q[0].setup);
          check(pp_data_out == sb_q[0].data, "R2 data at strobe rise",
                pp_data_out, sb_q[0].data);
        end else if (!abort_ok) begin
          check(1'b0, "R6 unexpected strobe", 1, 0);
        end
      end
      if (!pp_strobe && stb_prev) begin
        if (sb_q.size() > 0) begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc - rise_cyc == e.width, "R4 strobe width", cyc - rise_cyc, e.width);
          check(pp_data_out == e.data, "R5 data at strobe fall", pp_data_out, e.data);
        end else if (!abort_ok) begin
          check(1'b0, "R6 unexpected strobe end", 1, 0);
        end
      end
      stb_prev = pp_strobe;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check(pp_strobe == 1'b0, "R1 strobe", pp_strobe, 0);
    check(pp_data_out == 8'h00, "R1 data", pp_data_out, 0);
    check(pp_drv_en == 1'b1, "R1 drv_en", pp_drv_en, 1);
    reg_rd(2'd1, r); check(r == 16'h0008, "R1 R8 opctl idle", r, 16'h0008);
    reg_rd(2'd0, r); check(r == 16'h0000, "R1 timing", r, 0);
    reg_rd(2'd2, r); check(r == 16'h0000, "R1 xctl", r, 0);

    // R11 readback
    reg_wr(2'd0, 16'h0203);
    reg_rd(2'd0, r); check(r == 16'h0203, "R11 timing readback", r, 16'h0203);

    // R2 R3 R4 several patterns
    send(8'hA5, 3, 2);   wait_idle();
    reg_wr(2'd0, 16'h0000); send(8'h3C, 0, 0); wait_idle();
    reg_wr(2'd0, 16'h0501); send(8'h81, 1, 5); wait_idle();
    reg_wr(2'd0, 16'h070A); send(8'h7E, 10, 7); wait_idle();
    reg_wr(2'd0, 16'h017F); send(8'hFF, 127, 1); wait_idle();

    // R8 busy flag, R10 test mode, R5 ignored write
    reg_wr(2'd0, 16'h0414);
    send(8'h11, 20, 4);
    reg_rd(2'd1, r); check(r == 16'h0000, "R8 not idle during setup", r, 0);
    reg_wr(2'd0, 16'h8414);
    reg_rd(2'd0, r);
    check(r[15] == 1'b1 && r[14:7] == 8'h00 && r[6:0] >= 7'd1 && r[6:0] <= 7'd20,
          "R10 live setup count", r, 16'h8000);
    reg_wr(2'd3, 16'h005A);
    check(pp_data_out == 8'h11, "R5 ignored write", pp_data_out, 8'h11);
    wait_idle();
    reg_rd(2'd0, r); check(r == 16'h8000, "R10 idle counters", r, 16'h8000);
    reg_rd(2'd3, r); check(r == 16'h0011, "R5 data register", r, 16'h0011);

    // R9 pin readback
    pp_ack_in = 1'b1; pp_busy_in = 1'b0;
    repeat (4) @(negedge clk);
    reg_rd(2'd2, r); check(r == 16'h0002, "R9 ack", r, 16'h0002);
    pp_ack_in = 1'b0; pp_busy_in = 1'b1;
    repeat (4) @(negedge clk);
    reg_rd(2'd2, r); check(r == 16'h0004, "R9 busy", r, 16'h0004);
    pp_busy_in = 1'b0;
    repeat (4) @(negedge clk);

    // R6 input direction
    reg_wr(2'd2, 16'h0008);
    check(pp_drv_en == 1'b0, "R6 drv_en off", pp_drv_en, 0);
    reg_wr(2'd3, 16'h0022);
    repeat (10) @(negedge clk);
    check(pp_data_out == 8'h11, "R6 no transfer", pp_data_out, 8'h11);
    reg_rd(2'd1, r); check(r == 16'h0008, "R6 still idle", r, 16'h0008);
    reg_rd(2'd2, r); check(r == 16'h0008, "R9 dir bit", r, 16'h0008);
    reg_wr(2'd2, 16'h0000);

    // R7 soft reset abort
    reg_wr(2'd0, 16'h1E02);
    abort_ok = 1'b1;
    reg_wr(2'd3, 16'h0099);
    while (!pp_strobe) @(negedge clk);
    reg_rd(2'd2, r); check(r == 16'h0001, "R9 strobe bit", r, 16'h0001);
    reg_wr(2'd1, 16'h0080);
    check(pp_strobe == 1'b1, "R7 strobe before abort edge", pp_strobe, 1);
    @(negedge clk);
    check(pp_strobe == 1'b0, "R7 strobe aborted", pp_strobe, 0);
    reg_rd(2'd1, r); check(r == 16'h0088, "R7 srst sticky idle", r, 16'h0088);
    reg_wr(2'd3, 16'h0044);
    repeat (5) @(negedge clk);
    check(pp_data_out == 8'h99 && !pp_strobe, "R7 held in reset", pp_data_out, 8'h99);
    reg_rd(2'd1, r); check(r == 16'h0088, "R7 not self clearing", r, 16'h0088);
    reg_wr(2'd1, 16'h0000);
    abort_ok = 1'b0;
    reg_wr(2'd0, 16'h0302);
    send(8'h66, 2, 3);
    wait_idle();

    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2 all transfers done", sb_q.size(), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule